// File: doc/BRIEF.md
# CAN controller control and interrupt register block

This block is the software-visible control face of a CAN controller. It keeps the operating mode word, decodes write-only command strobes into single-cycle pulses toward the protocol engine, assembles a read-only status word from engine state and captured error information, and manages eight latched interrupt sources with individual enables that combine into one interrupt line.

A simple word-addressed bus reaches it. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`. Word 0 holds the mode, word 1 the commands, word 2 the status, word 3 the interrupt flags and word 4 the interrupt enables. The protocol engine reports events as one-cycle pulses on an eight-bit vector. It also reports its running state and the error and arbitration details that the block captures. Two of the mode fields guard the engine configuration and can only change while the controller sits in reset mode.

Top module: `canctl_regs`

## Requirements
- R1: After synchronous reset the mode word reads 0x01 (reset mode on), the status word reads 0x0000003C, the flag and enable words read 0, and `irq_o` is low.
- R2: Mode word layout: bit0 reset mode, bit1 listen-only, bit2 loopback, bit3 single-filter select, bit4 sleep. Bits 0 to 2 take every write. Bits 3 and 4 take a write only when bit0 was 1 before that write, and otherwise keep their value.
- R3: A write to word 1 drives `cmd_o` with wdata[5:0] for exactly the one cycle after the write edge and 0 otherwise. Command bits: 0 transmit, 1 abort, 2 release receive buffer, 3 clear overrun, 4 self-receive, 5 bus-off. Word 1 reads as 0.
- R4: Each bit of `ev_i` that is 1 sets the matching flag bit (word 3) at that edge, whether or not it is enabled. Bit order: 0 receive, 1 transmit done, 2 error warning, 3 data overrun, 4 wakeup, 5 error passive, 6 arbitration lost, 7 bus error.
- R5: Writing word 3 clears each flag whose wdata bit is 1 and leaves the flags whose wdata bit is 0. An event on the same edge as its clear leaves the flag set.
- R6: Word 4 is a read/write enable mask on bits 7:0, and `irq_o` is high exactly when some flag and its enable are both 1.
- R7: Status bit0 (receive ready) is set by event bit0. A release-receive command clears it only when `rx_more_i` is low. An event on the same edge keeps it set.
- R8: Status bit1 (data overrun) is set by event bit3 and cleared by the clear-overrun command.
- R9: On event bit7 the status word captures `err_type_i` into bits 23:22, `err_dir_i` into bit 21 and `err_seg_i` into bits 20:16. These fields hold their value without that event.
- R10: On event bit6 the status word captures `arb_pos_i` into bits 12:8. The field holds otherwise.
- R11: Status bits 7:2 show `eng_i` registered by one cycle (transmit buffer ready, transmit complete, receiving, transmitting, error status, bus off).
- R12: Word addresses 5 to 7 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| ev_i | input | 8 | Event pulses from the protocol engine |
| rx_more_i | input | 1 | Another received message is waiting |
| eng_i | input | 6 | Engine running state, mirrored to status 7:2 |
| err_type_i | input | 2 | Bus error kind (0 bit, 1 form, 2 stuff, 3 other) |
| err_dir_i | input | 1 | Error direction (0 transmit, 1 receive) |
| err_seg_i | input | 5 | Frame segment code at the error |
| arb_pos_i | input | 5 | Bit position where arbitration was lost |
| mode_o | output | 5 | Current mode word |
| cmd_o | output | 6 | One-cycle command pulses |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the collisions and the gating. A flag clear on the same edge as its event must leave the flag set, or an event is lost. A release command with another message waiting must keep receive-ready high, or that message would never be read. A write to the guarded mode bits outside reset mode must be dropped, or the filter and sleep settings change under a running engine. It also confirms that a disabled flag still latches but leaves `irq_o` low, that the command pulse lasts one cycle and never appears on a read, and that the captured error fields hold until the next matching event.

// File: rtl/canctl_pkg.sv
package canctl_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_IRQ  = 8;
    localparam int ENG_W    = 6;
    localparam int CMD_W    = 6;
    localparam int MODE_W   = 5;

    // word indices on the register bus
    localparam int W_MODE   = 0;
    localparam int W_CMD    = 1;
    localparam int W_STAT   = 2;
    localparam int W_FLAG   = 3;
    localparam int W_ENA    = 4;

    // event / flag / enable bit positions
    localparam int EV_RX    = 0;
    localparam int EV_TX    = 1;
    localparam int EV_WARN  = 2;
    localparam int EV_OVR   = 3;
    localparam int EV_WAKE  = 4;
    localparam int EV_PASV  = 5;
    localparam int EV_ARB   = 6;
    localparam int EV_BERR  = 7;

    typedef struct packed {
        logic sleep;
        logic single_filt;
        logic loopback;
        logic listen_only;
        logic in_reset;
    } mode_t;

    typedef struct packed {
        logic bus_off_req;
        logic self_rx;
        logic clr_ovr;
        logic rel_rx;
        logic abort;
        logic tx_req;
    } cmd_t;

    typedef struct packed {
        logic [1:0] kind;
        logic       dir;
        logic [4:0] seg;
    } berr_t;

    localparam mode_t MODE_RST = '{sleep: 1'b0, single_filt: 1'b0, loopback: 1'b0,
                                   listen_only: 1'b0, in_reset: 1'b1};
    localparam logic [ENG_W-1:0] ENG_RST = 6'b001111;

    function automatic logic [DATA_W-1:0] pack_status(
        input berr_t berr, input logic [4:0] arb,
        input logic [ENG_W-1:0] eng, input logic ovr, input logic rdy);
        return {8'h00, berr, 3'b000, arb, eng, ovr, rdy};
    endfunction

endpackage

// File: rtl/canctl_mode.sv
module canctl_mode
    import canctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  mode_t       wval,
    output mode_t       mode_q
);
    mode_t nxt;

    always_comb begin
        nxt = mode_q;
        if (we) begin
            nxt.in_reset    = wval.in_reset;
            nxt.listen_only = wval.listen_only;
            nxt.loopback    = wval.loopback;
            // guarded fields follow the reset bit held before this write
            if (mode_q.in_reset) begin
                nxt.single_filt = wval.single_filt;
                nxt.sleep       = wval.sleep;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RST;
        else     mode_q <= nxt;
    end
endmodule

// File: rtl/canctl_cmd.sv
module canctl_cmd
    import canctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  cmd_t        wval,
    output cmd_t        cmd_now,
    output cmd_t        cmd_q
);
    assign cmd_now = we ? wval : '0;

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_now;
    end
endmodule

// File: rtl/canctl_irq.sv
module canctl_irq
    import canctl_pkg::*;
#(
    parameter int N = NUM_IRQ
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic         clr_we,
    input  logic         ena_we,
    input  logic [N-1:0] wval,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] ena_q,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (ev[i])
                flag_q[i] <= 1'b1;
            else if (clr_we && wval[i])
                flag_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         ena_q <= '0;
        else if (ena_we) ena_q <= wval;
    end

    assign irq = |(flag_q & ena_q);
endmodule

// File: rtl/canctl_stat.sv
module canctl_stat
    import canctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_rx,
    input  logic              ev_ovr,
    input  logic              ev_berr,
    input  logic              ev_arb,
    input  logic              rel_rx,
    input  logic              clr_ovr,
    input  logic              rx_more,
    input  logic [ENG_W-1:0]  eng,
    input  berr_t             berr_in,
    input  logic [4:0]        arb_in,
    output logic [DATA_W-1:0] status
);
    logic             rdy_q, ovr_q;
    logic [ENG_W-1:0] eng_q;
    berr_t            berr_q;
    logic [4:0]       arb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q  <= 1'b0;
            ovr_q  <= 1'b0;
            eng_q  <= ENG_RST;
            berr_q <= '0;
            arb_q  <= '0;
        end else begin
            eng_q <= eng;
            if (ev_rx)                   rdy_q <= 1'b1;
            else if (rel_rx && !rx_more) rdy_q <= 1'b0;
            if (ev_ovr)                  ovr_q <= 1'b1;
            else if (clr_ovr)            ovr_q <= 1'b0;
            if (ev_berr)                 berr_q <= berr_in;
            if (ev_arb)                  arb_q  <= arb_in;
        end
    end

    assign status = pack_status(berr_q, arb_q, eng_q, ovr_q, rdy_q);
endmodule

// File: rtl/canctl_regs.sv
module canctl_regs
    import canctl_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [7:0]        ev_i,
    input  logic              rx_more_i,
    input  logic [5:0]        eng_i,
    input  logic [1:0]        err_type_i,
    input  logic              err_dir_i,
    input  logic [4:0]        err_seg_i,
    input  logic [4:0]        arb_pos_i,
    output logic [4:0]        mode_o,
    output logic [5:0]        cmd_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(W_MODE);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(W_CMD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(W_STAT);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(W_FLAG);
    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(W_ENA);

    mode_t              mode_w;
    cmd_t               cmd_now, cmd_w;
    logic [NUM_IRQ-1:0] flag_w, ena_w;
    logic [DATA_W-1:0]  stat_w;
    logic               unused_hi;

    assign unused_hi = ^wdata[31:8];

    canctl_mode u_mode (
        .clk(clk), .rst(rst),
        .we(wr_en && addr == A_MODE),
        .wval(mode_t'(wdata[MODE_W-1:0])),
        .mode_q(mode_w)
    );

    canctl_cmd u_cmd (
        .clk(clk), .rst(rst),
        .we(wr_en && addr == A_CMD),
        .wval(cmd_t'(wdata[CMD_W-1:0])),
        .cmd_now(cmd_now),
        .cmd_q(cmd_w)
    );

    canctl_irq #(.N(NUM_IRQ)) u_irq (
        .clk(clk), .rst(rst),
        .ev(ev_i),
        .clr_we(wr_en && addr == A_FLAG),
        .ena_we(wr_en && addr == A_ENA),
        .wval(wdata[NUM_IRQ-1:0]),
        .flag_q(flag_w),
        .ena_q(ena_w),
        .irq(irq_o)
    );

    canctl_stat u_stat (
        .clk(clk), .rst(rst),
        .ev_rx(ev_i[EV_RX]),
        .ev_ovr(ev_i[EV_OVR]),
        .ev_berr(ev_i[EV_BERR]),
        .ev_arb(ev_i[EV_ARB]),
        .rel_rx(cmd_now.rel_rx),
        .clr_ovr(cmd_now.clr_ovr),
        .rx_more(rx_more_i),
        .eng(eng_i),
        .berr_in('{kind: err_type_i, dir: err_dir_i, seg: err_seg_i}),
        .arb_in(arb_pos_i),
        .status(stat_w)
    );

    always_comb begin
        unique case (addr)
            A_MODE:  rdata = {{(DATA_W-MODE_W){1'b0}}, mode_w};
            A_STAT:  rdata = stat_w;
            A_FLAG:  rdata = {{(DATA_W-NUM_IRQ){1'b0}}, flag_w};
            A_ENA:   rdata = {{(DATA_W-NUM_IRQ){1'b0}}, ena_w};
            default: rdata = '0;  // command word and unmapped words
        endcase
    end

    assign mode_o = mode_w;
    assign cmd_o  = cmd_w;
endmodule

// File: rtl/canctl_regs_chk.sv
module canctl_regs_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [7:0]        ev_i,
    input logic              rx_more_i,
    input logic [4:0]        mode_o,
    input logic [5:0]        cmd_o,
    input logic [7:0]        flag_w,
    input logic [31:0]       stat_w
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(3);

    // R2: guarded mode bits never move while out of reset mode
    p_mode_guard_r2: assert property (@(posedge clk) disable iff (rst)
        (!mode_o[0]) |=> (mode_o[4:3] == $past(mode_o[4:3])));

    // R2: listen-only and loopback follow any mode write
    p_mode_free_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_MODE) |=> (mode_o[2:0] == $past(wdata[2:0])));

    // R3: a command write appears on cmd_o on the next cycle
    p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CMD) |=> (cmd_o == $past(wdata[5:0])));

    // R3: no command write, no pulse
    p_cmd_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_CMD) |=> (cmd_o == 6'd0));

    // R4 and R5: every pulsed event is latched, even under a clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_i != 8'd0) |=> ((flag_w & $past(ev_i)) == $past(ev_i)));

    // R5: a clear with no events removes the cleared flags
    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_FLAG && ev_i == 8'd0) |=> ((flag_w & $past(wdata[7:0])) == 8'd0));

    // R7: release with a message waiting keeps receive ready
    p_rel_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CMD && wdata[2] && rx_more_i) |=> (stat_w[0] == $past(stat_w[0])));
endmodule

bind canctl_regs canctl_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ev_i(ev_i), .rx_more_i(rx_more_i), .mode_o(mode_o), .cmd_o(cmd_o),
    .flag_w(flag_w), .stat_w(stat_w)
);

// File: tb/canctl_regs_tb_top.sv
`timescale 1ns/1ps
module canctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  ev_i = '0;
    logic        rx_more_i = 1'b0;
    logic [5:0]  eng_i = 6'b001111;
    logic [1:0]  err_type_i = '0;
    logic        err_dir_i = 1'b0;
    logic [4:0]  err_seg_i = '0;
    logic [4:0]  arb_pos_i = '0;
    logic [4:0]  mode_o;
    logic [5:0]  cmd_o;
    logic        irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    canctl_regs #(.ADDR_W(3)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ev_i(ev_i), .rx_more_i(rx_more_i), .eng_i(eng_i),
        .err_type_i(err_type_i), .err_dir_i(err_dir_i), .err_seg_i(err_seg_i),
        .arb_pos_i(arb_pos_i), .mode_o(mode_o), .cmd_o(cmd_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  wa;
        logic [31:0] wd;
        logic [7:0]  ev;
        logic        more;
        logic [2:0]  ra;
        logic [31:0] exp;
        logic        exp_irq;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd0, 32'h19, 8'h00, 1'b0, 3'd0, 32'h19,     1'b0, 4'd2},  // R2 guarded bits in reset mode
        '{1'b1, 3'd0, 32'h00, 8'h00, 1'b0, 3'd0, 32'h00,     1'b0, 4'd2},  // R2 leave reset mode
        '{1'b1, 3'd0, 32'h1E, 8'h00, 1'b0, 3'd0, 32'h06,     1'b0, 4'd2},  // R2 sleep/filter dropped
        '{1'b1, 3'd0, 32'h01, 8'h00, 1'b0, 3'd0, 32'h01,     1'b0, 4'd2},
        '{1'b0, 3'd0, 32'h00, 8'h01, 1'b0, 3'd2, 32'h3D,     1'b0, 4'd7},  // R7 receive ready set
        '{1'b0, 3'd0, 32'h00, 8'h00, 1'b0, 3'd3, 32'h01,     1'b0, 4'd4},  // R4 latched while disabled
        '{1'b1, 3'd4, 32'h01, 8'h00, 1'b0, 3'd4, 32'h01,     1'b1, 4'd6},  // R6 enable raises irq
        '{1'b1, 3'd3, 32'h00, 8'h00, 1'b0, 3'd3, 32'h01,     1'b1, 4'd5},  // R5 zero keeps
        '{1'b1, 3'd3, 32'h01, 8'h00, 1'b0, 3'd3, 32'h00,     1'b0, 4'd5},  // R5 one clears
        '{1'b1, 3'd1, 32'h04, 8'h00, 1'b1, 3'd2, 32'h3D,     1'b0, 4'd7},  // R7 release blocked
        '{1'b1, 3'd1, 32'h04, 8'h00, 1'b0, 3'd2, 32'h3C,     1'b0, 4'd7},  // R7 release clears
        '{1'b0, 3'd0, 32'h00, 8'h08, 1'b0, 3'd2, 32'h3E,     1'b0, 4'd8},  // R8 overrun set
        '{1'b1, 3'd1, 32'h08, 8'h00, 1'b0, 3'd2, 32'h3C,     1'b0, 4'd8},  // R8 overrun cleared
        '{1'b1, 3'd3, 32'hFF, 8'h08, 1'b0, 3'd3, 32'h08,     1'b0, 4'd5},  // R5 set beats clear
        '{1'b1, 3'd3, 32'hFF, 8'h00, 1'b0, 3'd3, 32'h00,     1'b0, 4'd5},
        '{1'b1, 3'd4, 32'hF0, 8'h0F, 1'b0, 3'd3, 32'h0F,     1'b0, 4'd6},  // R6 masked sources
        '{1'b0, 3'd0, 32'h00, 8'h10, 1'b0, 3'd3, 32'h1F,     1'b1, 4'd4},  // R4 wakeup bit4
        '{1'b1, 3'd1, 32'h01, 8'h00, 1'b0, 3'd1, 32'h00,     1'b1, 4'd3},  // R3 command reads zero
        '{1'b1, 3'd7, 32'hFF, 8'h00, 1'b0, 3'd7, 32'h00,     1'b1, 4'd12}, // R12 unmapped word
        '{1'b1, 3'd3, 32'hFF, 8'h00, 1'b0, 3'd3, 32'h00,     1'b0, 4'd5}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d,
                        input logic [7:0] ev, input logic more);
        wr_en = wr; addr = a; wdata = d; ev_i = ev; rx_more_i = more;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; ev_i = '0; rx_more_i = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset values
        rd(3'd0, v); check("R1 mode", v, 32'h01);
        rd(3'd2, v); check("R1 status", v, 32'h3C);
        rd(3'd3, v); check("R1 flags", v, 32'h00);
        rd(3'd4, v); check("R1 enable", v, 32'h00);
        check("R1 irq", {31'd0, irq_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wr, VEC[i].wa, VEC[i].wd, VEC[i].ev, VEC[i].more);
            rd(VEC[i].ra, v);
            check($sformatf("R%0d vec%0d data", VEC[i].rq, i), v, VEC[i].exp);
            check($sformatf("R6 vec%0d irq", i), {31'd0, irq_o}, {31'd0, VEC[i].exp_irq});
        end

        do_reset();
        // R3 pulse lasts one cycle
        step(1'b1, 3'd1, 32'h21, 8'h00, 1'b0);
        check("R3 pulse", {26'd0, cmd_o}, 32'h21);
        @(negedge clk);
        check("R3 pulse end", {26'd0, cmd_o}, 32'h00);

        // R9 bus error capture and hold
        err_type_i = 2'd2; err_dir_i = 1'b1; err_seg_i = 5'h1A;
        step(1'b0, 3'd0, 32'h0, 8'h80, 1'b0);
        rd(3'd2, v); check("R9 capture", v, 32'h00BA003C);
        err_type_i = 2'd1; err_dir_i = 1'b0; err_seg_i = 5'h03;
        step(1'b0, 3'd0, 32'h0, 8'h00, 1'b0);
        rd(3'd2, v); check("R9 hold", v, 32'h00BA003C);

        // R10 arbitration position
        arb_pos_i = 5'h13;
        step(1'b0, 3'd0, 32'h0, 8'h40, 1'b0);
        rd(3'd2, v); check("R10 capture", v, 32'h00BA133C);

        // R11 engine state mirrored one cycle later
        eng_i = 6'b110000;
        step(1'b0, 3'd0, 32'h0, 8'h00, 1'b0);
        rd(3'd2, v); check("R11 mirror", {24'd0, v[7:0]}, 32'hC0);

        // R7 receive event on the same edge as a release keeps ready
        step(1'b1, 3'd1, 32'h04, 8'h01, 1'b0);
        rd(3'd2, v); check("R7 set beats release", {31'd0, v[0]}, 32'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule